// File: doc/BRIEF.md
# Coarse-Fine Digital LDO Controller

This block computes the gate-enable codes for the power-transistor array of a digitally controlled low-dropout regulator. Its only feedback is one comparator bit that is high while the regulated output is below the target. The controller first finds a binary coarse code by successive approximation. The coarse code drives the large devices. Control then passes to a thermometer code of tiny devices, which the controller nudges by one device per decision to track the target.

The comparator bit is acted on only when the decision enable is high. This leaves the analog output time to settle between updates. A synchronous restart begins a new acquisition. The flags report three things: the coarse search has finished, the fine code is pinned at one end of its range, and the fine loop has settled into a one-step dither.

Top module: `dldo_ctrl`

## Requirements
- R1: While reset is low, and on the cycle after restart is high, coarse_code and fine_code are all zeros and coarse_done, fine_sat and locked are 0. The first decision enable after that places the trial bit: coarse_code becomes 1 followed by CW-1 zeros.
- R2: A cycle with dec_en low leaves coarse_code, fine_code and all flags unchanged.
- R3: On each later decision during the search, the current trial bit is kept if below is 1 and cleared if below is 0, and the next lower bit is set as the new trial. After CW decisions (the (CW+1)th enable), coarse_done goes to 1. The final coarse code is the largest code whose output is below the target, or 0 if there is none.
- R4: At the handoff, fine_code is preset to FN/2 ones in its low bits. fine_code is always a thermometer code: ones fill from bit 0 upward with no gaps.
- R5: After the handoff, each decision adds one 1 to fine_code when below is 1 and removes one when below is 0.
- R6: fine_code saturates at all zeros and at all FN ones, with no wraparound. fine_sat is 1 exactly when coarse_done is 1 and fine_code is at either end.
- R7: coarse_code does not change while coarse_done is 1.
- R8: locked goes to 1 once LOCK_N consecutive fine decisions have each reversed the direction of the decision before it. A decision in the same direction as the previous one clears locked.
- R9: restart overrides dec_en and takes effect from any phase, including during fine tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Synchronous restart of acquisition |
| dec_en | input | 1 | Decision enable; comparator sampled only when high |
| below | input | 1 | Comparator: 1 while output is below target |
| coarse_code | output | CW | Binary code for the large devices |
| fine_code | output | FN | Thermometer code for the small devices |
| coarse_done | output | 1 | Coarse search finished; fine tracking active |
| fine_sat | output | 1 | Fine code at zero or full scale |
| locked | output | 1 | Fine loop dithering about one position |

## Verification
A behavioural plant in the bench sets the output to 64 units per coarse LSB plus one unit per fine device. Targets are chosen so that the residue after the coarse search is small, at mid range, at the top of one coarse step, and near zero. Each of these gives a different coarse result and sends the fine code up, down or barely away from its preset. Targets above the full range and at zero drive the fine code into its two rails, which separates saturation from wraparound and shows that lock is not claimed there. Further directed cases check the early trial bits, a stalled decision enable, restart during tracking, and the loss of lock after a target step.

// File: rtl/dldo_ctrl.sv
module dldo_ctrl #(
  parameter int CW = 11,
  parameter int FN = 80,
  parameter int LOCK_N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          dec_en,
  input  logic          below,
  output logic [CW-1:0] coarse_code,
  output logic [FN-1:0] fine_code,
  output logic          coarse_done,
  output logic          fine_sat,
  output logic          locked
);
  localparam int IW = (CW > 1) ? $clog2(CW) : 1;
  localparam int LW = $clog2(LOCK_N + 1);
  localparam logic [FN-1:0] HALF = {{(FN - FN/2){1'b0}}, {(FN/2){1'b1}}};
  localparam logic [CW-1:0] MSB_TRIAL = {1'b1, {(CW-1){1'b0}}};

  typedef enum logic [1:0] {P_START, P_SAR, P_FINE} phase_t;

  phase_t        phase;
  logic [IW-1:0] idx;
  logic          prev_v, prev_up;
  logic [LW-1:0] rev_cnt;
  logic [CW-1:0] sar_next;
  logic [FN-1:0] fine_next;

  wire full     = fine_code[FN-1];
  wire empty    = ~fine_code[0];
  wire reversal = prev_v && (prev_up != below);

  always_comb begin
    sar_next = coarse_code;
    if (!below) sar_next[idx] = 1'b0;
    if (idx != '0) sar_next[idx - IW'(1)] = 1'b1;
  end

  always_comb begin
    fine_next = fine_code;
    if (below && !full)       fine_next = {fine_code[FN-2:0], 1'b1};
    else if (!below && !empty) fine_next = {1'b0, fine_code[FN-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase       <= P_START;
      idx         <= '0;
      coarse_code <= '0;
      fine_code   <= '0;
      prev_v      <= 1'b0;
      prev_up     <= 1'b0;
      rev_cnt     <= '0;
    end else if (dec_en) begin
      case (phase)
        P_START: begin
          coarse_code <= MSB_TRIAL;
          idx         <= IW'(CW - 1);
          phase       <= P_SAR;
        end
        P_SAR: begin
          coarse_code <= sar_next;
          if (idx == '0) begin
            phase     <= P_FINE;
            fine_code <= HALF;
          end else begin
            idx <= idx - IW'(1);
          end
        end
        default: begin
          fine_code <= fine_next;
          prev_v    <= 1'b1;
          prev_up   <= below;
          if (!reversal)                   rev_cnt <= '0;
          else if (rev_cnt != LW'(LOCK_N)) rev_cnt <= rev_cnt + LW'(1);
        end
      endcase
    end
  end

  assign coarse_done = (phase == P_FINE);
  assign fine_sat    = coarse_done && (full || empty);
  assign locked      = (rev_cnt == LW'(LOCK_N));
endmodule

// File: rtl/dldo_ctrl_chk.sv
module dldo_ctrl_chk #(
  parameter int CW = 11,
  parameter int FN = 80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          dec_en,
  input logic          below,
  input logic [CW-1:0] coarse_code,
  input logic [FN-1:0] fine_code,
  input logic          coarse_done,
  input logic          fine_sat,
  input logic          locked
);
  a_r1_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (coarse_code == '0 && fine_code == '0 && !coarse_done && !locked));

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !restart) |=> ($stable(coarse_code) && $stable(fine_code) && $stable(locked)));

  a_r4_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    (((fine_code + FN'(1)) & fine_code) == '0));

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_done && dec_en && !restart && below && !fine_code[FN-1]) |=>
    ($countones(fine_code) == $countones($past(fine_code)) + 1));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_done && dec_en && !restart && !below && fine_code[0]) |=>
    ($countones(fine_code) + 1 == $countones($past(fine_code))));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_done && !restart && fine_code[FN-1] && below) |=> fine_code[FN-1]);

  a_r6_sat_only_fine: assert property (@(posedge clk) disable iff (!rst_n)
    fine_sat |-> coarse_done);

  a_r7_coarse_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_done && !restart) |=> $stable(coarse_code));
endmodule

bind dldo_ctrl dldo_ctrl_chk #(.CW(CW), .FN(FN)) chk_i (
  .clk(clk), .rst_n(rst_n), .restart(restart), .dec_en(dec_en), .below(below),
  .coarse_code(coarse_code), .fine_code(fine_code), .coarse_done(coarse_done),
  .fine_sat(fine_sat), .locked(locked)
);

// File: tb/dldo_ctrl_tb_top.sv
module dldo_ctrl_tb_top;
  localparam int CW = 11, FN = 80;

  logic clk = 0, rst_n = 0, restart = 0, dec_en = 0;
  logic [CW-1:0] coarse_code;
  logic [FN-1:0] fine_code;
  logic coarse_done, fine_sat, locked;
  int target = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wire below = (int'(coarse_code) * 64 + $countones(fine_code)) < target;

  dldo_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .dec_en(dec_en), .below(below),
    .coarse_code(coarse_code), .fine_code(fine_code), .coarse_done(coarse_done),
    .fine_sat(fine_sat), .locked(locked)
  );

  // target, expected coarse, residue m (fine settles at m-1 or m)
  localparam int NV = 5;
  localparam int VEC [NV][3] = '{
    '{50000, 781, 16},
    '{1000, 15, 40},
    '{131000, 2046, 56},
    '{65536, 1023, 64},
    '{3, 0, 3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) dec_en = 1;
      @(negedge clk) dec_en = 0;
    end
  endtask

  task automatic do_restart();
    @(negedge clk) restart = 1;
    @(negedge clk) restart = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ones;
    int c0, f0;
    repeat (3) @(negedge clk);
    chk(coarse_code == 0 && fine_code == 0, "R1 reset codes", int'(coarse_code), 0);
    chk(!coarse_done && !fine_sat && !locked, "R1 reset flags", int'(coarse_done), 0);
    rst_n = 1;
    target = 1000;
    step(1);
    chk(coarse_code == 11'h400, "R1 msb trial", int'(coarse_code), 1024);
    step(1);
    chk(coarse_code == 11'h200, "R3 bit cleared next trial", int'(coarse_code), 512);
    repeat (4) @(negedge clk);
    chk(coarse_code == 11'h200 && fine_code == 0, "R2 stall holds", int'(coarse_code), 512);
    step(9);
    chk(!coarse_done, "R3 not done after CW-1 decisions", int'(coarse_done), 0);

    for (int v = 0; v < NV; v++) begin
      target = VEC[v][0];
      do_restart();
      chk(coarse_code == 0 && fine_code == 0 && !coarse_done, "R9 restart clears",
          int'(coarse_code), 0);
      step(12);
      chk(coarse_done, "R3 done after CW decisions", int'(coarse_done), 1);
      chk(int'(coarse_code) == VEC[v][1], "R3 coarse result", int'(coarse_code), VEC[v][1]);
      chk(fine_code == {40'd0, {40{1'b1}}}, "R4 half preset", $countones(fine_code), 40);
      step(100);
      ones = $countones(fine_code);
      chk(ones == VEC[v][2] || ones == VEC[v][2] - 1, "R5 fine settles", ones, VEC[v][2]);
      chk(locked, "R8 locked on dither", int'(locked), 1);
      chk(int'(coarse_code) == VEC[v][1], "R7 coarse frozen", int'(coarse_code), VEC[v][1]);
      chk(!fine_sat, "R6 not saturated mid range", int'(fine_sat), 0);
    end

    target = 1000;
    do_restart();
    step(112);
    chk(locked, "R8 lock before step", int'(locked), 1);
    target = 1020;
    step(2);
    chk(!locked, "R8 lock lost on same direction", int'(locked), 0);
    c0 = int'(coarse_code);
    f0 = $countones(fine_code);
    repeat (5) @(negedge clk);
    chk(int'(coarse_code) == c0 && $countones(fine_code) == f0, "R2 stall in fine",
        $countones(fine_code), f0);
    @(negedge clk) begin dec_en = 1; restart = 1; end
    @(negedge clk) begin dec_en = 0; restart = 0; end
    chk(coarse_code == 0 && fine_code == 0 && !coarse_done, "R9 restart beats dec_en",
        int'(coarse_code), 0);

    target = 200000;
    step(12);
    chk(coarse_code == 11'h7ff, "R3 all bits kept", int'(coarse_code), 2047);
    step(60);
    chk(fine_code == {FN{1'b1}}, "R6 top saturate no wrap", $countones(fine_code), 80);
    chk(fine_sat && !locked, "R6 fine_sat high", int'(fine_sat), 1);

    target = 0;
    do_restart();
    step(12);
    chk(coarse_code == 0, "R3 no code below target", int'(coarse_code), 0);
    step(60);
    chk(fine_code == 0, "R6 bottom saturate no wrap", $countones(fine_code), 0);
    chk(fine_sat && !locked, "R6 fine_sat low end", int'(fine_sat), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule